// File: doc/BRIEF.md
# Dual-Slope Symmetric PWM Timer

This block is a 16-bit up/down timer that drives two centre-aligned PWM pins. On each enabled tick the counter climbs from zero to a top value, holds there for one tick, then falls back to zero, holds there for one tick, and climbs again. The top value comes from one of three fixed constants, a software-written period register, or the active compare value of channel A. The mode input picks the source.

Each of the two channels compares the counter with its active compare value. A match moves the channel's pin latch to one level on the way up and to the other level on the way down. A per-channel pin mode input picks non-inverting or inverting polarity, or leaves the pin disconnected. Software writes to a compare value go to a shadow register. The shadow is copied into the active register only on the top tick, so a period is never cut in the middle. A write to the period register takes effect on the next cycle.

Four sticky flags report events: a compare match on each channel, top reached, and bottom reached. The block has no data stream, so it has no valid/ready handshake. Every pin is a plain level. Writes are accepted on every cycle and are never back-pressured. A write does not depend on `tick`.

Top module: `pcpwm_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the counter goes to 0 and the direction to up. Both pin latches, all flags, the period register and every compare register (shadow and active) go to 0. Both pins read low.
- R2: The counter changes only on edges where `tick` is high, and it moves by exactly one per tick. With `tick` low, `count_o` holds its value.
- R3: The top value is selected by `mode`: 0 gives 0x00FF, 1 gives 0x01FF, 2 gives 0x03FF, 3 gives the period register, 4 gives channel A's active compare value, and 5 to 7 give 0x00FF. Any selected value below 3 is raised to 3.
- R4: When the counter is at or above top while counting up, the next tick moves it to count−1 and the direction to down, so top lasts exactly one tick. When it is at 0 while counting down, the next tick moves it to 1 and the direction to up.
- R5: With `wr_en` high, `wr_sel` picks the target: 0 is the period register, 1 is the channel A shadow, 2 is the channel B shadow, and 3 writes nothing. The period register takes `wr_data` at that edge. A shadow is copied into its active register on the tick that leaves top, using the shadow's value from before any write at that same edge.
- R6: Pin mode 2 (non-inverting): a tick whose counter equals the active compare value clears the pin latch if the counter is moving up and sets it if it is moving down.
- R7: Pin mode 3 (inverting): the same match sets the latch while moving up and clears it while moving down.
- R8: Pin modes 0 and 1 drive the pin low, and matches leave the latch unchanged. When a connected mode is selected again, the pin shows the latch.
- R9: A tick whose counter equals channel A's (or B's) active compare value sets `flag_cmp_a` (or `flag_cmp_b`). In mode 4 the top tick also sets `flag_cmp_a`.
- R10: In mode 3 the top tick sets `flag_capt`.
- R11: A tick at 0 while counting down sets `flag_ovf`.
- R12: Flags are sticky. Bit 0 of `flag_clr` clears compare A, bit 1 clears compare B, bit 2 clears top reached, and bit 3 clears bottom reached. Clearing works on any cycle. A flag that is set and cleared at the same edge ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable (prescaled tick) |
| mode | input | 3 | Top source select |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 period, 1 compare A, 2 compare B |
| wr_data | input | 16 | Write data |
| com_a | input | 2 | Pin mode, channel A |
| com_b | input | 2 | Pin mode, channel B |
| flag_clr | input | 4 | Write-one-to-clear for the flags |
| count_o | output | 16 | Current counter value |
| pwm_a | output | 1 | PWM pin, channel A |
| pwm_b | output | 1 | PWM pin, channel B |
| flag_cmp_a | output | 1 | Compare A matched |
| flag_cmp_b | output | 1 | Compare B matched |
| flag_capt | output | 1 | Top reached in period-register mode |
| flag_ovf | output | 1 | Bottom reached |

## Verification
A wrong direction bit or an off-by-one turnaround appears on `count_o` at the first tick after top or bottom. It also shifts every later pin edge by a whole tick. A compare value loaded from its shadow at the wrong time does not show until the next match. That is at most one full up/down period later, seen as a pin edge at the wrong count or a missing compare flag. A latch that takes the wrong polarity shows on the pin in the cycle after the match tick.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;
  typedef enum logic [2:0] {
    TOP_FIX8  = 3'd0,
    TOP_FIX9  = 3'd1,
    TOP_FIX10 = 3'd2,
    TOP_CAPT  = 3'd3,
    TOP_CMPA  = 3'd4
  } top_src_e;

  typedef enum logic [1:0] {
    PIN_OFF    = 2'd0,
    PIN_OFF2   = 2'd1,
    PIN_NONINV = 2'd2,
    PIN_INV    = 2'd3
  } pin_mode_e;

  localparam logic [1:0] WSEL_CAPT = 2'd0;
  localparam logic [1:0] WSEL_CMPA = 2'd1;
  localparam logic [1:0] WSEL_CMPB = 2'd2;

  localparam int FL_CMPA = 0;
  localparam int FL_CMPB = 1;
  localparam int FL_CAPT = 2;
  localparam int FL_OVF  = 3;
  localparam int NFLAGS  = 4;
  localparam int NCHAN   = 2;
endpackage

// File: rtl/pcpwm_top_sel.sv
module pcpwm_top_sel
  import pcpwm_pkg::*;
#(
  parameter int W       = 16,
  parameter int MIN_TOP = 3
) (
  input  logic [2:0]   mode,
  input  logic [W-1:0] capt,
  input  logic [W-1:0] cmpa_act,
  output logic [W-1:0] top_eff
);
  logic [W-1:0] raw;

  always_comb begin
    case (mode)
      TOP_FIX9:  raw = W'(16'h01FF);
      TOP_FIX10: raw = W'(16'h03FF);
      TOP_CAPT:  raw = capt;
      TOP_CMPA:  raw = cmpa_act;
      default:   raw = W'(16'h00FF);
    endcase
    top_eff = (raw < W'(MIN_TOP)) ? W'(MIN_TOP) : raw;
  end
endmodule

// File: rtl/pcpwm_counter.sv
module pcpwm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         up,
  output logic         top_evt,
  output logic         bot_evt
);
  assign top_evt = tick && up && (cnt >= top);
  assign bot_evt = tick && !up && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (tick) begin
      if (top_evt) begin
        cnt <= cnt - 1'b1;
        up  <= 1'b0;
      end else if (bot_evt) begin
        cnt <= W'(1);
        up  <= 1'b1;
      end else if (up) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R2: no tick, no motion
  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(cnt) && $stable(up)));

  // R2: each tick moves the counter by one
  assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> ((cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1)));

  // R4: top lasts one tick, then the counter falls
  assert_top_turn_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && up && cnt == top) |=> (!up && cnt == $past(cnt) - 1'b1));

  // R4: bottom turnaround
  assert_bottom_turn_R4: assert property (@(posedge clk) disable iff (rst)
    bot_evt |=> (up && cnt == W'(1)));
endmodule

// File: rtl/pcpwm_channel.sv
module pcpwm_channel
  import pcpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr_shadow,
  input  logic [W-1:0] wr_data,
  input  logic         load,
  input  logic [W-1:0] cnt,
  input  logic         up,
  input  logic [1:0]   pin_mode,
  output logic [W-1:0] act,
  output logic         match,
  output logic         pin
);
  logic [W-1:0] shadow_q;
  logic [W-1:0] act_q;
  logic         oc_q;
  logic         connected;
  logic         invert;

  assign connected = pin_mode[1];
  assign invert    = pin_mode[0];
  assign match     = tick && (cnt == act_q);
  assign act       = act_q;
  assign pin       = connected & oc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      act_q    <= '0;
      oc_q     <= 1'b0;
    end else begin
      if (wr_shadow) shadow_q <= wr_data;
      if (load)      act_q    <= shadow_q;
      if (match && connected) oc_q <= (~up) ^ invert;
    end
  end

  // R5: active value follows the shadow only at the top tick
  assert_shadow_load_R5: assert property (@(posedge clk) disable iff (rst)
    load |=> (act_q == $past(shadow_q)));

  assert_hold_active_R5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(act_q));

  // R6: non-inverting polarity
  assert_noninv_R6: assert property (@(posedge clk) disable iff (rst)
    (match && pin_mode == PIN_NONINV) |=> (oc_q == !$past(up)));

  // R7: inverting polarity
  assert_inv_R7: assert property (@(posedge clk) disable iff (rst)
    (match && pin_mode == PIN_INV) |=> (oc_q == $past(up)));

  // R8: a disconnected pin leaves the latch alone
  assert_off_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    !connected |=> $stable(oc_q));
endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
  import pcpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [2:0]   mode,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   com_a,
  input  logic [1:0]   com_b,
  input  logic [3:0]   flag_clr,
  output logic [W-1:0] count_o,
  output logic         pwm_a,
  output logic         pwm_b,
  output logic         flag_cmp_a,
  output logic         flag_cmp_b,
  output logic         flag_capt,
  output logic         flag_ovf
);
  logic [W-1:0]              capt_q;
  logic [W-1:0]              top_eff;
  logic [W-1:0]              cnt;
  logic                      up;
  logic                      top_evt;
  logic                      bot_evt;
  logic [NFLAGS-1:0]         flags_q;
  logic [NFLAGS-1:0]         flag_set;
  logic [NCHAN-1:0][1:0]     ch_mode;
  logic [NCHAN-1:0]          ch_wr;
  logic [NCHAN-1:0]          ch_match;
  logic [NCHAN-1:0]          ch_pin;
  logic [NCHAN-1:0][W-1:0]   ch_act;

  assign ch_mode[0] = com_a;
  assign ch_mode[1] = com_b;
  assign ch_wr[0]   = wr_en && (wr_sel == WSEL_CMPA);
  assign ch_wr[1]   = wr_en && (wr_sel == WSEL_CMPB);

  pcpwm_top_sel #(.W(W)) u_top_sel (
    .mode     (mode),
    .capt     (capt_q),
    .cmpa_act (ch_act[0]),
    .top_eff  (top_eff)
  );

  pcpwm_counter #(.W(W)) u_counter (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .top     (top_eff),
    .cnt     (cnt),
    .up      (up),
    .top_evt (top_evt),
    .bot_evt (bot_evt)
  );

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    pcpwm_channel #(.W(W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .wr_shadow (ch_wr[c]),
      .wr_data   (wr_data),
      .load      (top_evt),
      .cnt       (cnt),
      .up        (up),
      .pin_mode  (ch_mode[c]),
      .act       (ch_act[c]),
      .match     (ch_match[c]),
      .pin       (ch_pin[c])
    );
  end

  always_comb begin
    flag_set          = '0;
    flag_set[FL_CMPA] = ch_match[0] || (top_evt && mode == TOP_CMPA);
    flag_set[FL_CMPB] = ch_match[1];
    flag_set[FL_CAPT] = top_evt && (mode == TOP_CAPT);
    flag_set[FL_OVF]  = bot_evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      capt_q  <= '0;
      flags_q <= '0;
    end else begin
      if (wr_en && wr_sel == WSEL_CAPT) capt_q <= wr_data;
      flags_q <= (flags_q & ~flag_clr) | flag_set;
    end
  end

  assign count_o    = cnt;
  assign pwm_a      = ch_pin[0];
  assign pwm_b      = ch_pin[1];
  assign flag_cmp_a = flags_q[FL_CMPA];
  assign flag_cmp_b = flags_q[FL_CMPB];
  assign flag_capt  = flags_q[FL_CAPT];
  assign flag_ovf   = flags_q[FL_OVF];

  // R5: period register write is immediate
  assert_capt_write_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == WSEL_CAPT) |=> (capt_q == $past(wr_data)));

  // R10: top flag in period-register mode
  assert_capt_flag_R10: assert property (@(posedge clk) disable iff (rst)
    (top_evt && mode == TOP_CAPT) |=> flag_capt);

  // R11: bottom flag
  assert_ovf_flag_R11: assert property (@(posedge clk) disable iff (rst)
    bot_evt |=> flag_ovf);

  // R12: flags not cleared stay set
  assert_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_q & $past(flags_q & ~flag_clr)) == $past(flags_q & ~flag_clr)));
endmodule

// File: tb/pcpwm_timer_bench.sv
`timescale 1ns/1ps
module pcpwm_timer_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0;
  logic [2:0]   mode = 3'd0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   com_a = 2'd0;
  logic [1:0]   com_b = 2'd0;
  logic [3:0]   flag_clr = 4'd0;
  logic [W-1:0] count_o;
  logic         pwm_a, pwm_b, flag_cmp_a, flag_cmp_b, flag_capt, flag_ovf;

  pcpwm_timer #(.W(W)) u_pcpwm_timer (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .com_a(com_a), .com_b(com_b),
    .flag_clr(flag_clr), .count_o(count_o), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .flag_cmp_a(flag_cmp_a), .flag_cmp_b(flag_cmp_b),
    .flag_capt(flag_capt), .flag_ovf(flag_ovf)
  );

  always #2.5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;

  // reference state, derived from the requirements
  logic [15:0] m_cnt, m_capt, m_bufa, m_bufb, m_acta, m_actb;
  logic        m_up, m_oca, m_ocb;
  logic [3:0]  m_flag;

  function automatic logic [15:0] exp_top(logic [2:0] md, logic [15:0] cp, logic [15:0] ca);
    logic [15:0] r;
    case (md)
      3'd1: r = 16'h01FF;
      3'd2: r = 16'h03FF;
      3'd3: r = cp;
      3'd4: r = ca;
      default: r = 16'h00FF;
    endcase
    if (r < 16'd3) r = 16'd3;
    return r;
  endfunction

  function automatic logic exp_pin(logic [1:0] cm, logic oc);
    return cm[1] & oc;
  endfunction

  function automatic int tri_wave(int k, int top);
    int v;
    v = k % (2 * top);
    return (v <= top) ? v : 2 * top - v;
  endfunction

  task automatic model_step();
    logic [15:0] t;
    logic te, be, ma, mb;
    if (rst) begin
      m_cnt = 0; m_up = 1; m_capt = 0; m_bufa = 0; m_bufb = 0;
      m_acta = 0; m_actb = 0; m_oca = 0; m_ocb = 0; m_flag = 0;
      return;
    end
    t  = exp_top(mode, m_capt, m_acta);
    te = tick && m_up && (m_cnt >= t);
    be = tick && !m_up && (m_cnt == 0);
    ma = tick && (m_cnt == m_acta);
    mb = tick && (m_cnt == m_actb);
    m_flag = (m_flag & ~flag_clr) |
             {be, te && mode == 3'd3, mb, ma || (te && mode == 3'd4)};
    if (ma && com_a[1]) m_oca = (!m_up) ^ com_a[0];
    if (mb && com_b[1]) m_ocb = (!m_up) ^ com_b[0];
    if (te) begin m_acta = m_bufa; m_actb = m_bufb; end
    if (wr_en && wr_sel == 2'd1) m_bufa = wr_data;
    if (wr_en && wr_sel == 2'd2) m_bufb = wr_data;
    if (wr_en && wr_sel == 2'd0) m_capt = wr_data;
    if (tick) begin
      if (te) begin m_cnt = m_cnt - 1; m_up = 0; end
      else if (be) begin m_cnt = 1; m_up = 1; end
      else if (m_up) m_cnt = m_cnt + 1;
      else m_cnt = m_cnt - 1;
    end
  endtask

  task automatic note(bit ok, string tag, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    note(count_o == m_cnt, "R2", "count", count_o, m_cnt);
    note(pwm_a == exp_pin(com_a, m_oca), "R6", "pwm_a", pwm_a, exp_pin(com_a, m_oca));
    note(pwm_b == exp_pin(com_b, m_ocb), "R7", "pwm_b", pwm_b, exp_pin(com_b, m_ocb));
    note(flag_cmp_a == m_flag[0], "R9", "flag_cmp_a", flag_cmp_a, m_flag[0]);
    note(flag_cmp_b == m_flag[1], "R9", "flag_cmp_b", flag_cmp_b, m_flag[1]);
    note(flag_capt == m_flag[2], "R10", "flag_capt", flag_capt, m_flag[2]);
    note(flag_ovf == m_flag[3], "R11", "flag_ovf", flag_ovf, m_flag[3]);
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    rst = 1; tick = 0; wr_en = 0; flag_clr = 0;
    step(); step();
    rst = 0;
  endtask

  task automatic write_reg(logic [1:0] sel, logic [15:0] d);
    tick = 0; wr_en = 1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic run_peak(int n, output int pk);
    pk = 0; tick = 1;
    for (int i = 0; i < n; i++) begin
      step();
      if (int'(count_o) > pk) pk = int'(count_o);
    end
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    int pk;
    bit seen;
    int guard;
    void'($urandom(32'd20240611));
    @(negedge clk);

    // R1: reset state
    com_a = 2'd2; com_b = 2'd3;
    do_reset();
    note(count_o == 0, "R1", "count", count_o, 0);
    note(pwm_a == 0 && pwm_b == 0, "R1", "pins", {pwm_a, pwm_b}, 0);
    note({flag_ovf, flag_capt, flag_cmp_b, flag_cmp_a} == 4'd0, "R1", "flags",
         {flag_ovf, flag_capt, flag_cmp_b, flag_cmp_a}, 0);

    // R2: no tick, counter still; R5 period write immediate
    mode = 3'd3;
    write_reg(2'd0, 16'd5);
    repeat (8) step();
    note(count_o == 0, "R2", "held count", count_o, 0);

    // R4: triangle with top 5
    tick = 1;
    for (int k = 1; k <= 12; k++) begin
      step();
      note(int'(count_o) == tri_wave(k, 5), "R4", "triangle", count_o, tri_wave(k, 5));
    end

    // R3: fixed tops
    for (int m = 0; m < 4; m++) begin
      int tp;
      tp = (m == 0) ? 255 : (m == 1) ? 511 : (m == 2) ? 1023 : 255;
      do_reset();
      mode = (m == 3) ? 3'd5 : 3'(m);
      run_peak(2 * tp + 8, pk);
      note(pk == tp, "R3", "fixed top", pk, tp);
    end

    // R3: tiny period clamped to 3
    do_reset();
    mode = 3'd3;
    write_reg(2'd0, 16'd1);
    run_peak(12, pk);
    note(pk == 3, "R3", "clamped top", pk, 3);

    // R5: mode 4, shadow A loads at top
    do_reset();
    mode = 3'd4;
    write_reg(2'd1, 16'd9);
    run_peak(4, pk);
    note(pk == 3, "R5", "peak before load", pk, 3);
    run_peak(30, pk);
    note(pk == 9, "R5", "peak after load", pk, 9);

    // R6 / R7: polarity
    do_reset();
    mode = 3'd3; com_a = 2'd2; com_b = 2'd3;
    write_reg(2'd0, 16'd10);
    write_reg(2'd1, 16'd4);
    write_reg(2'd2, 16'd4);
    tick = 1;
    guard = 0;
    do begin step(); guard++; end
    while (!(m_acta == 4 && !m_up && m_cnt == 3) && guard < 200);
    note(pwm_a == 1, "R6", "set on down match", pwm_a, 1);
    note(pwm_b == 0, "R7", "clear on down match", pwm_b, 0);
    guard = 0;
    do begin step(); guard++; end
    while (!(m_up && m_cnt == 5) && guard < 200);
    note(pwm_a == 0, "R6", "clear on up match", pwm_a, 0);
    note(pwm_b == 1, "R7", "set on up match", pwm_b, 1);

    // R8: disconnected pin stays low
    com_a = 2'd0;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (pwm_a) seen = 1;
    end
    note(!seen, "R8", "disconnected pin", seen, 0);
    com_a = 2'd2;

    // R9..R12: flags observed, sticky, cleared
    tick = 0;
    repeat (3) step();
    note(flag_cmp_a == 1, "R12", "sticky cmp_a", flag_cmp_a, 1);
    note(flag_cmp_b == 1, "R9", "cmp_b set", flag_cmp_b, 1);
    note(flag_capt == 1, "R10", "capt set", flag_capt, 1);
    note(flag_ovf == 1, "R11", "ovf set", flag_ovf, 1);
    flag_clr = 4'b1111;
    step();
    flag_clr = 4'b0000;
    note({flag_ovf, flag_capt, flag_cmp_b, flag_cmp_a} == 4'd0, "R12", "cleared",
         {flag_ovf, flag_capt, flag_cmp_b, flag_cmp_a}, 0);

    // random phase, checked cycle by cycle against the reference
    do_reset();
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = int'($urandom % 1000);
      tick = ($urandom % 4) != 0;
      if (r < 4) mode = ($urandom % 10 < 8) ? 3'(3 + $urandom % 2) : 3'($urandom % 8);
      wr_en = ($urandom % 8) == 0;
      wr_sel = 2'($urandom % 4);
      wr_data = 16'($urandom % 48);
      flag_clr = (($urandom % 16) == 0) ? 4'($urandom % 16) : 4'd0;
      if (r >= 990) com_a = 2'($urandom % 4);
      if (r <= 10 && r >= 5) com_b = 2'($urandom % 4);
      rst = (($urandom % 4000) == 0);
      step();
    end
    rst = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule